// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block is the combinational arithmetic and logic unit of a load-store RISC core's execute stage. Each cycle it receives two operands (the second one already through the operand shifter), a 4-bit operation code, a set-flags bit, the current negative, zero, carry and overflow flags, and the carry-out of the shifter. From these it produces a result, a write-enable that tells the register file whether to keep that result, and the next value of the four flags.

Sixteen operations are covered: the move group, the add and subtract family (including the reverse and carry-consuming forms), the bitwise group with bit-clear, and four compare/test operations that only set flags. For subtraction the carry flag has the "no borrow" sense, so a flag-setting add on the low words followed by an add-with-carry on the high words builds a wide add. A flag-setting subtract followed by a subtract-with-carry builds a wide subtract in the same way.

Top module: `dp_alu`

## Requirements
- R1: Opcode values select the arithmetic operations as follows: 4 = a+b, 5 = a+b+C, 2 = a−b, 6 = a−b−(1−C), 3 = b−a, 7 = b−a−(1−C). The result is taken modulo 2^WIDTH.
- R2: Opcode values select the bitwise and move operations as follows: 0 = a AND b, 1 = a XOR b, 12 = a OR b, 14 = a AND NOT b, 13 = b, 15 = NOT b.
- R3: With set_flags=1, an addition-type operation (4, 5, 11) sets C to the unsigned carry out of bit WIDTH−1. A subtraction-type operation (2, 3, 6, 7, 10) sets C to 1 when no borrow occurs and to 0 when a borrow occurs. For example, 5−3 gives C=1 and 3−5 gives C=0.
- R4: With set_flags=1, an arithmetic or compare operation sets V to 1 exactly when the signed result of the operation lies outside the WIDTH-bit two's-complement range.
- R5: With set_flags=1, N equals bit WIDTH−1 of the operation's value, and Z is 1 exactly when that value is zero.
- R6: With set_flags=1, the bitwise, move and test operations (0, 1, 8, 9, 12, 13, 14, 15) copy shift_carry into C and leave V equal to v_in.
- R7: With set_flags=0, every operation leaves all four outgoing flags equal to the incoming flags.
- R8: The compare/test operations 8 (a AND b), 9 (a XOR b), 10 (a−b) and 11 (a+b) hold result_we at 0 and set the flags from their value as in R3 to R6.
- R9: Every operation other than 8 to 11 drives result_we to 1.
- R10: A flag-setting add of the low words, followed by an add-with-carry of the high words that takes the first step's C as c_in, gives the correct 2·WIDTH-bit sum and carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_op | input | WIDTH | First operand |
| b_op | input | WIDTH | Second operand, already shifted |
| opcode | input | 4 | Operation code |
| set_flags | input | 1 | Update flags when 1 |
| n_in | input | 1 | Current negative flag |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| shift_carry | input | 1 | Carry-out of the operand shifter |
| result | output | WIDTH | Operation value |
| result_we | output | 1 | Write the result to the register file |
| n_out | output | 1 | Next negative flag |
| z_out | output | 1 | Next zero flag |
| c_out | output | 1 | Next carry flag |
| v_out | output | 1 | Next overflow flag |

## Verification
On every evaluation, the assertions check several properties: that compare/test operations never raise the write-enable, that flags hold when set_flags is low, that bitwise operations pass the shifter carry and keep V, and that Z agrees with the value. They also compare the subtraction carry against an unsigned comparison of minuend against subtrahend plus borrow. The actual arithmetic values, the signed overflow cases, the exact bit patterns of each bitwise operation and the two-step wide add can only be shown by the bench's scenarios. The bench also compares every vector against a behavioural model built on wide integers.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  // carry-in source for the adder
  typedef enum logic [1:0] {
    CIN_ZERO  = 2'd0,
    CIN_ONE   = 2'd1,
    CIN_FLAG  = 2'd2
  } cin_mode_e;

  // bitwise function select
  typedef enum logic [2:0] {
    LG_AND  = 3'd0,
    LG_XOR  = 3'd1,
    LG_OR   = 3'd2,
    LG_CLR  = 3'd3,
    LG_PASS = 3'd4,
    LG_NOT  = 3'd5
  } logic_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
  import dp_alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output logic             is_arith,
  output logic             swap_ops,
  output logic             inv_second,
  output cin_mode_e        cin_mode,
  output logic_sel_e       lg_sel,
  output logic             writes_result
);

  always_comb begin
    is_arith   = 1'b0;
    swap_ops   = 1'b0;
    inv_second = 1'b0;
    cin_mode   = CIN_ZERO;
    lg_sel     = LG_AND;
    unique case (alu_op_e'(opcode))
      OP_AND, OP_TST: lg_sel = LG_AND;
      OP_EOR, OP_TEQ: lg_sel = LG_XOR;
      OP_ORR:         lg_sel = LG_OR;
      OP_BIC:         lg_sel = LG_CLR;
      OP_MOV:         lg_sel = LG_PASS;
      OP_MVN:         lg_sel = LG_NOT;
      OP_ADD, OP_CMN: is_arith = 1'b1;
      OP_ADC: begin
        is_arith = 1'b1;
        cin_mode = CIN_FLAG;
      end
      OP_SUB, OP_CMP: begin
        is_arith   = 1'b1;
        inv_second = 1'b1;
        cin_mode   = CIN_ONE;
      end
      OP_SBC: begin
        is_arith   = 1'b1;
        inv_second = 1'b1;
        cin_mode   = CIN_FLAG;
      end
      OP_RSB: begin
        is_arith   = 1'b1;
        swap_ops   = 1'b1;
        inv_second = 1'b1;
        cin_mode   = CIN_ONE;
      end
      OP_RSC: begin
        is_arith   = 1'b1;
        swap_ops   = 1'b1;
        inv_second = 1'b1;
        cin_mode   = CIN_FLAG;
      end
      default: ;
    endcase
    // the compare/test group shares the top opcode bits 2'b10
    writes_result = (opcode[OPC_W-1 -: 2] != 2'b10);
  end

endmodule

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_val,
  input  logic [WIDTH-1:0] b_val,
  input  logic             swap_ops,
  input  logic             inv_second,
  input  cin_mode_e        cin_mode,
  input  logic             carry_flag,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             overflow
);

  localparam int EXT_W = WIDTH + 1;

  logic [WIDTH-1:0] first_term;
  logic [WIDTH-1:0] second_term;
  logic             carry_in;

  function automatic logic [EXT_W-1:0] add_ext(
    input logic [WIDTH-1:0] x,
    input logic [WIDTH-1:0] y,
    input logic             ci
  );
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
  endfunction

  function automatic logic signed_ovf(
    input logic xs,
    input logic ys,
    input logic rs
  );
    return (xs == ys) && (rs != xs);
  endfunction

  logic [EXT_W-1:0] wide_sum;

  always_comb begin
    first_term  = swap_ops ? b_val : a_val;
    second_term = swap_ops ? a_val : b_val;
    if (inv_second) second_term = ~second_term;
    unique case (cin_mode)
      CIN_ONE:  carry_in = 1'b1;
      CIN_FLAG: carry_in = carry_flag;
      default:  carry_in = 1'b0;
    endcase
    wide_sum  = add_ext(first_term, second_term, carry_in);
    sum       = wide_sum[WIDTH-1:0];
    carry_out = wide_sum[WIDTH];
    overflow  = signed_ovf(first_term[WIDTH-1], second_term[WIDTH-1], sum[WIDTH-1]);
  end

endmodule

// File: rtl/dp_alu_bitwise.sv
module dp_alu_bitwise
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_val,
  input  logic [WIDTH-1:0] b_val,
  input  logic_sel_e       lg_sel,
  output logic [WIDTH-1:0] value
);

  always_comb begin
    unique case (lg_sel)
      LG_AND:  value = a_val & b_val;
      LG_XOR:  value = a_val ^ b_val;
      LG_OR:   value = a_val | b_val;
      LG_CLR:  value = a_val & ~b_val;
      LG_PASS: value = b_val;
      LG_NOT:  value = ~b_val;
      default: value = '0;
    endcase
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_op,
  input  logic [WIDTH-1:0] b_op,
  input  logic [3:0]       opcode,
  input  logic             set_flags,
  input  logic             n_in,
  input  logic             z_in,
  input  logic             c_in,
  input  logic             v_in,
  input  logic             shift_carry,
  output logic [WIDTH-1:0] result,
  output logic             result_we,
  output logic             n_out,
  output logic             z_out,
  output logic             c_out,
  output logic             v_out
);

  localparam int EXT_W = WIDTH + 1;

  // named internal events, visible to the assertions
  logic             is_arith;
  logic             swap_ops;
  logic             inv_second;
  cin_mode_e        cin_mode;
  logic_sel_e       lg_sel;
  logic             writes_result;
  logic [WIDTH-1:0] arith_val;
  logic             arith_carry;
  logic             arith_ovf;
  logic [WIDTH-1:0] bitwise_val;
  flags_t           flags_cur;
  flags_t           flags_nxt;

  dp_alu_decode u_decode (
    .opcode        (opcode),
    .is_arith      (is_arith),
    .swap_ops      (swap_ops),
    .inv_second    (inv_second),
    .cin_mode      (cin_mode),
    .lg_sel        (lg_sel),
    .writes_result (writes_result)
  );

  dp_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_val      (a_op),
    .b_val      (b_op),
    .swap_ops   (swap_ops),
    .inv_second (inv_second),
    .cin_mode   (cin_mode),
    .carry_flag (c_in),
    .sum        (arith_val),
    .carry_out  (arith_carry),
    .overflow   (arith_ovf)
  );

  dp_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a_val  (a_op),
    .b_val  (b_op),
    .lg_sel (lg_sel),
    .value  (bitwise_val)
  );

  always_comb begin
    flags_cur = '{n: n_in, z: z_in, c: c_in, v: v_in};
    result    = is_arith ? arith_val : bitwise_val;
    result_we = writes_result;
    flags_nxt = flags_cur;
    if (set_flags) begin
      flags_nxt.n = result[WIDTH-1];
      flags_nxt.z = (result == '0);
      flags_nxt.c = is_arith ? arith_carry : shift_carry;
      flags_nxt.v = is_arith ? arith_ovf   : v_in;
    end
    n_out = flags_nxt.n;
    z_out = flags_nxt.z;
    c_out = flags_nxt.c;
    v_out = flags_nxt.v;
  end

  // ---------------------------------------------------------------
  // Checks evaluated whenever the inputs settle
  // ---------------------------------------------------------------
  logic             chk_is_sub;
  logic [WIDTH-1:0] chk_minuend;
  logic [WIDTH-1:0] chk_subtr;
  logic             chk_borrow;
  logic [EXT_W-1:0] chk_need;

  always_comb begin
    chk_is_sub  = 1'b0;
    chk_minuend = a_op;
    chk_subtr   = b_op;
    chk_borrow  = 1'b0;
    case (opcode)
      4'h2, 4'hA: chk_is_sub = 1'b1;
      4'h6: begin chk_is_sub = 1'b1; chk_borrow = ~c_in; end
      4'h3: begin chk_is_sub = 1'b1; chk_minuend = b_op; chk_subtr = a_op; end
      4'h7: begin
        chk_is_sub  = 1'b1; chk_minuend = b_op; chk_subtr = a_op;
        chk_borrow  = ~c_in;
      end
      default: ;
    endcase
    chk_need = {1'b0, chk_subtr} + {{WIDTH{1'b0}}, chk_borrow};

    if (opcode[3:2] == 2'b10)
      AST_TEST_NO_WRITE: assert (!result_we);   // R8
    if (!set_flags)
      AST_FLAGS_HOLD: assert ({n_out, z_out, c_out, v_out} == {n_in, z_in, c_in, v_in});   // R7
    if (set_flags && !is_arith)
      AST_BITWISE_CV: assert (c_out == shift_carry && v_out == v_in);   // R6
    if (set_flags)
      AST_ZERO_FLAG: assert (z_out == (result == '0) && n_out == result[WIDTH-1]);   // R5
    if (set_flags && chk_is_sub)
      AST_NO_BORROW: assert (c_out == ({1'b0, chk_minuend} >= chk_need));   // R3
  end

endmodule

// File: tb/tb_dp_alu.sv
module tb_dp_alu;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_op = '0, b_op = '0;
  logic [3:0]   opcode = 4'h0;
  logic         set_flags = 1'b0;
  logic         n_in = 0, z_in = 0, c_in = 0, v_in = 0, shift_carry = 0;
  logic [W-1:0] result;
  logic         result_we, n_out, z_out, c_out, v_out;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_alu #(.WIDTH(W)) dut (
    .a_op(a_op), .b_op(b_op), .opcode(opcode), .set_flags(set_flags),
    .n_in(n_in), .z_in(z_in), .c_in(c_in), .v_in(v_in),
    .shift_carry(shift_carry),
    .result(result), .result_we(result_we),
    .n_out(n_out), .z_out(z_out), .c_out(c_out), .v_out(v_out)
  );

  // behavioural reference: wide integer arithmetic
  logic [W-1:0] m_res;
  logic         m_we, m_n, m_z, m_c, m_v;

  task automatic model(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic s, input logic [3:0] fl, input logic sc);
    longint ua, ub, sa, sb, ur, sr, k;
    logic arith;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    k = fl[1] ? 64'sd1 : 64'sd0;
    arith = 1'b1;
    ur = 0; sr = 0;
    case (op)
      4'h4, 4'hB: begin ur = ua + ub;         sr = sa + sb;         end
      4'h5:       begin ur = ua + ub + k;     sr = sa + sb + k;     end
      4'h2, 4'hA: begin ur = ua - ub;         sr = sa - sb;         end
      4'h6:       begin ur = ua - ub - (1-k); sr = sa - sb - (1-k); end
      4'h3:       begin ur = ub - ua;         sr = sb - sa;         end
      4'h7:       begin ur = ub - ua - (1-k); sr = sb - sa - (1-k); end
      default: arith = 1'b0;
    endcase
    m_we = !(op >= 4'h8 && op <= 4'hB);
    if (arith) m_res = ur[W-1:0];
    else begin
      case (op)
        4'h0, 4'h8: m_res = a & b;
        4'h1, 4'h9: m_res = a ^ b;
        4'hC:       m_res = a | b;
        4'hE:       m_res = a & ~b;
        4'hD:       m_res = b;
        default:    m_res = ~b;
      endcase
    end
    {m_n, m_z, m_c, m_v} = fl;
    if (s) begin
      m_n = m_res[W-1];
      m_z = (m_res == '0);
      if (arith) begin
        if (op inside {4'h4, 4'h5, 4'hB}) m_c = (ur >= (64'sd1 <<< W));
        else                              m_c = (ur >= 0);
        m_v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end else begin
        m_c = sc;
      end
    end
  endtask

  // drive at a rising edge, compare at the following falling edge
  task automatic run(input string tag, input logic [3:0] op, input logic [W-1:0] a,
                     input logic [W-1:0] b, input logic s, input logic [3:0] fl, input logic sc);
    @(posedge clk);
    opcode = op; a_op = a; b_op = b; set_flags = s;
    {n_in, z_in, c_in, v_in} = fl; shift_carry = sc;
    model(op, a, b, s, fl, sc);
    @(negedge clk);
    tests++;
    if ({result, result_we, n_out, z_out, c_out, v_out} !== {m_res, m_we, m_n, m_z, m_c, m_v}) begin
      fails++;
      $display("FAIL %s op=%h a=%h b=%h: got res=%h we=%b nzcv=%b%b%b%b exp res=%h we=%b nzcv=%b%b%b%b",
               tag, op, a, b, result, result_we, n_out, z_out, c_out, v_out,
               m_res, m_we, m_n, m_z, m_c, m_v);
    end
  endtask

  task automatic expect_bit(input string tag, input logic got, input logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] lo_sum, hi_sum;
    logic         lo_c;
    repeat (2) @(posedge clk);
    rst = 1'b0;

    // idle state: all-zero inputs select AND of zeros
    run("R2 idle", 4'h0, '0, '0, 1'b0, 4'b0000, 1'b0);

    // R1 arithmetic values
    run("R1 add",  4'h4, 32'd7, 32'd9, 1'b0, 4'b0000, 1'b0);
    run("R1 adc",  4'h5, 32'd7, 32'd9, 1'b0, 4'b0010, 1'b0);
    run("R1 sbc",  4'h6, 32'd20, 32'd5, 1'b0, 4'b0000, 1'b0);
    run("R1 rsb",  4'h3, 32'd4, 32'd10, 1'b0, 4'b0000, 1'b0);
    run("R1 rsc",  4'h7, 32'd4, 32'd10, 1'b0, 4'b0000, 1'b0);
    // R3 borrow sense
    run("R3 5-3",  4'h2, 32'd5, 32'd3, 1'b1, 4'b0000, 1'b0);
    expect_bit("R3 5-3 carry", c_out, 1'b1);
    run("R3 3-5",  4'h2, 32'd3, 32'd5, 1'b1, 4'b0010, 1'b0);
    expect_bit("R3 3-5 carry", c_out, 1'b0);
    run("R3 add carry", 4'h4, 32'hFFFF_FFFF, 32'd1, 1'b1, 4'b0000, 1'b0);
    run("R3 sbc equal no c", 4'h6, 32'd8, 32'd8, 1'b1, 4'b0000, 1'b0);
    // R4 signed overflow
    run("R4 add ovf", 4'h4, 32'h7FFF_FFFF, 32'd1, 1'b1, 4'b0000, 1'b0);
    run("R4 sub ovf", 4'h2, 32'h8000_0000, 32'd1, 1'b1, 4'b0000, 1'b0);
    run("R4 rsc ovf", 4'h7, 32'd1, 32'h8000_0000, 1'b1, 4'b0010, 1'b0);
    // R2 bitwise
    run("R2 bic", 4'hE, 32'h1111_1111, 32'h0110_0101, 1'b0, 4'b0000, 1'b0);
    run("R2 mvn", 4'hF, 32'h0, 32'h0000_00FF, 1'b0, 4'b0000, 1'b0);
    run("R2 orr", 4'hC, 32'hF000_0000, 32'h0000_000F, 1'b0, 4'b0000, 1'b0);
    // R5 / R6 flag-setting move of zero keeps V, C from shifter
    run("R6 movs zero", 4'hD, 32'h5, 32'h0, 1'b1, 4'b1011, 1'b0);
    expect_bit("R5 movs zero Z", z_out, 1'b1);
    expect_bit("R6 movs zero V kept", v_out, 1'b1);
    run("R6 mvns neg", 4'hF, 32'h0, 32'h0, 1'b1, 4'b0100, 1'b1);
    // R7 no flag update
    run("R7 sub hold", 4'h2, 32'd3, 32'd5, 1'b0, 4'b0101, 1'b0);
    run("R7 mov hold", 4'hD, 32'd0, 32'd0, 1'b0, 4'b1010, 1'b1);
    // R8 compare/test
    run("R8 cmp", 4'hA, 32'd5, 32'd5, 1'b1, 4'b0000, 1'b0);
    expect_bit("R8 cmp no write", result_we, 1'b0);
    run("R8 cmn", 4'hB, 32'h7FFF_FFFF, 32'd1, 1'b1, 4'b0000, 1'b0);
    run("R8 tst", 4'h8, 32'hF0, 32'h0F, 1'b1, 4'b0001, 1'b1);
    run("R8 teq", 4'h9, 32'hAB, 32'hAB, 1'b1, 4'b0000, 1'b0);

    // R10 two-step wide add
    run("R10 low", 4'h4, 32'hFFFF_FFF0, 32'h0000_0020, 1'b1, 4'b0000, 1'b0);
    lo_sum = result; lo_c = c_out;
    run("R10 high", 4'h5, 32'h0000_0001, 32'h0000_0002, 1'b0, {2'b00, lo_c, 1'b0}, 1'b0);
    hi_sum = result;
    tests++;
    if ({hi_sum, lo_sum} !== 64'h0000_0004_0000_0010) begin
      fails++;
      $display("FAIL R10 wide sum got=%h exp=%h", {hi_sum, lo_sum}, 64'h0000_0004_0000_0010);
    end

    // every opcode with pseudo-random operands and flags (R1 R2 R9)
    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < 24; i++) begin
        run((op >= 8 && op <= 11) ? "R8 sweep" : "R9 sweep", 4'(op),
            $urandom(), (i % 4 == 0) ? 32'h8000_0000 : $urandom(),
            1'(i % 3 != 0), 4'($urandom()), 1'($urandom()));
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule